// File: doc/BRIEF.md
# Balanced 24-Slot Symbol Encoder

This block turns four slowly changing signal values and one auxiliary bit into a stream of 24-slot symbols for a single-wire, DC-balanced link. At the start of each symbol it takes the four values and encodes them as an extended Hamming code: seven Hamming bits plus one overall parity bit, eight coded bits in all. It then sends each coded bit in one slot and its inverse in the next slot. The auxiliary bit goes out early in the symbol, and its inverse follows much later. Six fixed framing slots, three ones and three zeros, complete the symbol. Together these slots let a receiver find the symbol boundary even when the line is inverted.

A downstream serializer sets the pace. Each one-cycle advance strobe moves the output to the next slot. A symbol-start flag marks slot 0. A sequencer drives the block through four named states:

- `ST_IDLE`: after reset, nothing has been issued yet.
- `ST_HEAD`: slot 0 is presented.
- `ST_BODY`: one of slots 1 to 22 is presented.
- `ST_TAIL`: slot 23 is presented.

The transitions are:

- *start*: `ST_IDLE` to `ST_HEAD` on the first strobe, which also loads the inputs.
- *enter body*: `ST_HEAD` to `ST_BODY` on a strobe.
- *step*: `ST_BODY` to `ST_BODY` on a strobe while below slot 22.
- *finish body*: `ST_BODY` to `ST_TAIL` on a strobe at slot 22.
- *wrap*: `ST_TAIL` to `ST_HEAD` on a strobe, which loads the inputs again.

Without a strobe, every state holds.

Top module: `balanced_slot_encoder`

## Requirements
- R1: While reset is asserted, and after reset until the first advance strobe, `slot_out` and `sym_start` are both 0.
- R2: Each clock cycle with `slot_adv` high moves the output to the next slot, with the new value visible right after that clock edge. Without a strobe, both outputs hold. After slot 23, the next slot is slot 0.
- R3: The fixed slots carry these values: slots 0, 12 and 23 are 1, and slots 5, 11 and 18 are 0.
- R4: The coded bits a to h sit in slots 1, 3, 7, 9, 13, 15, 19 and 21. The slot directly after each of them (2, 4, 8, 10, 14, 16, 20, 22) carries its inverse.
- R5: Slot 6 carries the auxiliary bit and slot 17 carries its inverse.
- R6: The coded bits a to g are Hamming positions 1 to 7, defined as follows:
  - The data bits are d1 = `sig_in[0]`, d2 = `sig_in[1]`, d3 = `sig_in[2]` and d4 = `sig_in[3]`.
  - The parity bits are p1 = d1^d2^d4, p2 = d1^d3^d4 and p3 = d2^d3^d4.
  - In order, a to g are p1, p2, d1, p3, d2, d3 and d4.
  - h is the even parity over a to g.
- R7: `sig_in` and `aux_in` are sampled only on the strobe that issues slot 0. Changes to them during the rest of the symbol have no effect on that symbol.
- R8: `sym_start` is 1 exactly while slot 0 is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_adv | input | 1 | Advance strobe from the serializer, one slot per high cycle |
| sig_in | input | 4 | Four payload signal values |
| aux_in | input | 1 | Auxiliary bit |
| slot_out | output | 1 | Value of the slot currently presented |
| sym_start | output | 1 | High while slot 0 is presented |

## Verification
The block has a single configuration: four payload bits and 24 slots, fixed by the package constants. This small payload lets the bench send every one of the 16 payload values with both auxiliary levels, back to back. It compares all 24 slots of every symbol against a codeword that the bench computes arithmetically. Gaps of zero to two idle cycles between strobes check that the outputs hold between strobes. After each slot-0 strobe, the bench inverts the inputs, which shows that they are sampled only at the symbol start.

// File: rtl/bse_pkg.sv
package bse_pkg;

    localparam int SLOT_COUNT = 24;
    localparam int IDX_W      = $clog2(SLOT_COUNT);
    localparam int PAYLOAD_W  = 4;
    localparam int HAM_N      = 7;
    localparam int CODE_W     = HAM_N + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_TAIL
    } seq_state_t;

    typedef enum logic [2:0] {
        ROLE_ONE,
        ROLE_ZERO,
        ROLE_CODE,
        ROLE_CODE_INV,
        ROLE_AUX,
        ROLE_AUX_INV
    } slot_role_t;

    // Role of each slot within the symbol; the layout is what a receiver decodes.
    function automatic slot_role_t role_of(input int unsigned s);
        case (s)
            0, 12, 23:                        role_of = ROLE_ONE;
            5, 11, 18:                        role_of = ROLE_ZERO;
            6:                                role_of = ROLE_AUX;
            17:                               role_of = ROLE_AUX_INV;
            1, 3, 7, 9, 13, 15, 19, 21:       role_of = ROLE_CODE;
            default:                          role_of = ROLE_CODE_INV;
        endcase
    endfunction

    // Index of the coded bit carried by a code slot or its inverse partner.
    function automatic int unsigned code_sel(input int unsigned s);
        case (s)
            1, 2:    code_sel = 0;
            3, 4:    code_sel = 1;
            7, 8:    code_sel = 2;
            9, 10:   code_sel = 3;
            13, 14:  code_sel = 4;
            15, 16:  code_sel = 5;
            19, 20:  code_sel = 6;
            21, 22:  code_sel = 7;
            default: code_sel = 0;
        endcase
    endfunction

endpackage

// File: rtl/ham_ext_encoder.sv
module ham_ext_encoder
    import bse_pkg::*;
(
    input  logic [PAYLOAD_W-1:0] data_i,
    output logic [CODE_W-1:0]    code_o
);

    localparam int PAR_BITS = $clog2(HAM_N + 1);

    logic [HAM_N:1] pos;

    always_comb begin
        int unsigned di;
        pos = '0;
        di  = 0;
        // Data fills the non-power-of-two positions in ascending order.
        for (int unsigned p = 1; p <= HAM_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                pos[p] = data_i[di];
                di++;
            end
        end
        // Each check bit covers the positions sharing its index bit.
        for (int unsigned k = 0; k < PAR_BITS; k++) begin
            logic acc;
            acc = 1'b0;
            for (int unsigned p = 1; p <= HAM_N; p++) begin
                if (((p >> k) & 1) == 1 && (p & (p - 1)) != 0)
                    acc ^= pos[p];
            end
            pos[1 << k] = acc;
        end
        code_o[HAM_N-1:0] = pos[HAM_N:1];
        code_o[HAM_N]     = ^pos[HAM_N:1];
    end

endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
    import bse_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output seq_state_t       state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             load_o
);

    localparam logic [IDX_W-1:0] IDX_PRE_TAIL = IDX_W'(SLOT_COUNT - 2);
    localparam logic [IDX_W-1:0] IDX_ONE      = IDX_W'(1);

    seq_state_t       state_q, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
        end
    end

    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (adv_i) begin
                    state_n = ST_HEAD;
                    idx_n   = '0;
                end
            end
            ST_HEAD: begin
                if (adv_i) begin
                    state_n = ST_BODY;
                    idx_n   = IDX_ONE;
                end
            end
            ST_BODY: begin
                if (adv_i) begin
                    idx_n = idx_q + IDX_ONE;
                    if (idx_q == IDX_PRE_TAIL)
                        state_n = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (adv_i) begin
                    state_n = ST_HEAD;
                    idx_n   = '0;
                end
            end
            default: begin
                state_n = ST_IDLE;
                idx_n   = '0;
            end
        endcase
    end

    always_comb begin
        state_o = state_q;
        idx_o   = idx_q;
        load_o  = adv_i && (state_q == ST_IDLE || state_q == ST_TAIL);
    end

endmodule

// File: rtl/slot_mapper.sv
module slot_mapper
    import bse_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              aux_i,
    output logic              bit_o
);

    logic [SLOT_COUNT-1:0] slot_bits;

    for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
        localparam slot_role_t ROLE = role_of(s);
        localparam int unsigned SEL = code_sel(s);
        if (ROLE == ROLE_ONE) begin : g_one
            assign slot_bits[s] = 1'b1;
        end else if (ROLE == ROLE_ZERO) begin : g_zero
            assign slot_bits[s] = 1'b0;
        end else if (ROLE == ROLE_AUX) begin : g_aux
            assign slot_bits[s] = aux_i;
        end else if (ROLE == ROLE_AUX_INV) begin : g_auxn
            assign slot_bits[s] = ~aux_i;
        end else if (ROLE == ROLE_CODE) begin : g_code
            assign slot_bits[s] = code_i[SEL];
        end else begin : g_coden
            assign slot_bits[s] = ~code_i[SEL];
        end
    end

    always_comb begin
        bit_o = 1'b0;
        if (int'(idx_i) < SLOT_COUNT)
            bit_o = slot_bits[idx_i];
    end

endmodule

// File: rtl/balanced_slot_encoder.sv
module balanced_slot_encoder
    import bse_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_adv,
    input  logic [3:0] sig_in,
    input  logic       aux_in,
    output logic       slot_out,
    output logic       sym_start
);

    seq_state_t        seq_state;
    logic [IDX_W-1:0]  seq_idx;
    logic              cap_load;
    logic [CODE_W-1:0] code_now;
    logic [CODE_W-1:0] code_q;
    logic              aux_q;
    logic              map_bit;

    slot_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (slot_adv),
        .state_o (seq_state),
        .idx_o   (seq_idx),
        .load_o  (cap_load)
    );

    ham_ext_encoder u_ham (
        .data_i (sig_in),
        .code_o (code_now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            aux_q  <= 1'b0;
        end else if (cap_load) begin
            code_q <= code_now;
            aux_q  <= aux_in;
        end
    end

    slot_mapper u_map (
        .idx_i  (seq_idx),
        .code_i (code_q),
        .aux_i  (aux_q),
        .bit_o  (map_bit)
    );

    always_comb begin
        slot_out  = (seq_state != ST_IDLE) && map_bit;
        sym_start = (seq_state == ST_HEAD);
    end

endmodule

// File: rtl/bse_checker.sv
module bse_checker
    import bse_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              slot_adv,
    input logic              slot_out,
    input logic              sym_start,
    input seq_state_t        state,
    input logic [IDX_W-1:0]  idx,
    input logic              load,
    input logic [CODE_W-1:0] code
);

    logic active;
    logic aux_seen;
    logic is_lead;
    logic is_fixed;
    logic fixed_val;

    assign active = (state != ST_IDLE);

    always_comb begin
        is_lead = 1'b0;
        case (int'(idx))
            1, 3, 7, 9, 13, 15, 19, 21: is_lead = 1'b1;
            default:                    is_lead = 1'b0;
        endcase
        is_fixed  = 1'b1;
        fixed_val = 1'b0;
        case (int'(idx))
            0, 12, 23: fixed_val = 1'b1;
            5, 11, 18: fixed_val = 1'b0;
            default:   is_fixed  = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            aux_seen <= 1'b0;
        else if (active && int'(idx) == 6)
            aux_seen <= slot_out;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!slot_out && !sym_start));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_adv |=> ($stable(slot_out) && $stable(sym_start)));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_adv && active && int'(idx) == SLOT_COUNT - 1) |=> sym_start);

    assert_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && is_fixed) |-> (slot_out == fixed_val));

    assert_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_adv && active && is_lead) |=> (slot_out != $past(slot_out)));

    assert_aux_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && int'(idx) == 17) |-> (slot_out != aux_seen));

    assert_even_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_start |-> ($countones(code) % 2 == 0));

    assert_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(code));

    assert_start_slot0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sym_start |-> (slot_out && idx == '0));

endmodule

bind balanced_slot_encoder bse_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_adv  (slot_adv),
    .slot_out  (slot_out),
    .sym_start (sym_start),
    .state     (seq_state),
    .idx       (seq_idx),
    .load      (cap_load),
    .code      (code_q)
);

// File: tb/balanced_slot_encoder_tb.sv
module balanced_slot_encoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_adv = 1'b0;
    logic [3:0] sig_in = 4'h0;
    logic       aux_in = 1'b0;
    logic       slot_out;
    logic       sym_start;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    balanced_slot_encoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_adv  (slot_adv),
        .sig_in    (sig_in),
        .aux_in    (aux_in),
        .slot_out  (slot_out),
        .sym_start (sym_start)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Expected slot value from the requirement formulas (R3 R4 R5 R6).
    function automatic logic exp_bit(input int p, input logic [3:0] s, input logic v);
        logic [7:0] cw;
        cw[2] = s[0];
        cw[4] = s[1];
        cw[5] = s[2];
        cw[6] = s[3];
        cw[0] = s[0] ^ s[1] ^ s[3];
        cw[1] = s[0] ^ s[2] ^ s[3];
        cw[3] = s[1] ^ s[2] ^ s[3];
        cw[7] = ^cw[6:0];
        case (p)
            0, 12, 23: return 1'b1;
            5, 11, 18: return 1'b0;
            6:  return v;
            17: return ~v;
            1:  return cw[0];   2:  return ~cw[0];
            3:  return cw[1];   4:  return ~cw[1];
            7:  return cw[2];   8:  return ~cw[2];
            9:  return cw[3];   10: return ~cw[3];
            13: return cw[4];   14: return ~cw[4];
            15: return cw[5];   16: return ~cw[5];
            19: return cw[6];   20: return ~cw[6];
            21: return cw[7];   default: return ~cw[7];
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] pay;
        logic       av;
        logic       so_prev;
        logic       ss_prev;

        repeat (3) @(negedge clk);
        chk(slot_out, 1'b0, "R1 slot_out in reset");
        chk(sym_start, 1'b0, "R1 sym_start in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(slot_out, 1'b0, "R1 slot_out idle after reset");
        chk(sym_start, 1'b0, "R1 sym_start idle after reset");

        for (int n = 0; n < 34; n++) begin
            pay = 4'(n % 16);
            av  = 1'((n / 16) % 2);
            for (int p = 0; p < 24; p++) begin
                so_prev = slot_out;
                ss_prev = sym_start;
                for (int g = 0; g < (n + p) % 3; g++) begin
                    @(negedge clk);
                    chk(slot_out, so_prev, "R2 hold slot_out without strobe");
                    chk(sym_start, ss_prev, "R2 hold sym_start without strobe");
                end
                @(negedge clk);
                if (p == 0) begin
                    sig_in = pay;
                    aux_in = av;
                end
                slot_adv = 1'b1;
                @(negedge clk);
                slot_adv = 1'b0;
                chk(slot_out, exp_bit(p, pay, av),
                    $sformatf("R3 R4 R5 R6 R7 sym %0d slot %0d", n, p));
                chk(sym_start, (p == 0), $sformatf("R8 R2 sym_start sym %0d slot %0d", n, p));
                if (p == 0) begin
                    sig_in = ~pay;
                    aux_in = ~av;
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule